// File: doc/BRIEF.md
# Peripheral DMA Transfer Controller with Selectable Termination

This block moves data words between a local buffer and an external bus under control of a small register port. Software writes a configuration word, a byte count and then a command opcode. The opcode picks the direction and one of two bus roles. In the slave role, the block raises a request line and counts words that the external side qualifies with its acknowledge and a read or write strobe. In the master role, the block generates its own acknowledge and read or write strobes at one word every other cycle.

A transfer can end in four ways: the byte counter runs out, an external end-of-transfer pin pulses, the local packet engine flags a short packet, or software issues a stop opcode. The counter can be switched off in the slave role, so that only the end-of-transfer sources and the stop opcode apply. The master role always uses the counter and pays no attention to the external end-of-transfer pin. A sticky three-bit reason register records which causes fired. Software clears its bits by writing ones.

Top module: `xfer_dma_ctrl`

## Requirements
- R1: While idle, a write of opcode 00h (slave read), 01h (slave write), 06h (master read) or 07h (master write) to address 0 sets `busy` from the next cycle. Any other opcode leaves the block idle.
- R2: While busy, a command write of any opcode other than the stop opcode 0Fh has no effect. Stop ends the transfer on its write cycle and sets no reason bit.
- R3: In the slave role, `dreq` equals `busy`. A word moves in each busy cycle with `ext_ack` high and `ext_rd` or `ext_wr` high. When the counter is active, each word lowers `cnt_left` by 1 (config bit 0 = 0, 8-bit bus) or by 2 (bit 0 = 1, 16-bit bus), saturating at 0.
- R4: With the counter active, the transfer ends on the word that takes `cnt_left` to zero, or in its first busy cycle if `cnt_left` is already zero. This sets reason bit 2.
- R5: In the slave role with config bit 1 (counter off) set, `cnt_left` holds its written value and never ends the transfer.
- R6: A high `eot_in` in a busy slave-role cycle ends the transfer and sets reason bit 1. A high `short_pkt` in any busy cycle ends the transfer and sets reason bit 0. No reason bit rises while idle.
- R7: In the master role, `dreq` stays low and one word moves every second busy cycle, starting in the second. Config bits 3:2 select the strobes: 0 gives the read or write strobe only, 1 gives `mst_ack` only, and 2 or 3 give both. `mst_rd` is used for reads and `mst_wr` for writes, and the two are never high together.
- R8: In the master role, config bit 1 is ignored (the counter is always active) and `eot_in` has no effect.
- R9: When several causes occur in one cycle, all of their reason bits are set. `busy` and `dreq` are low from the next cycle.
- R10: Writing address 3 clears each reason bit whose data bit is 1. A cause in the same cycle as the clear wins, so the bit stays set.
- R11: After reset, `busy`, `dreq`, the master strobes, `reason` and `cnt_left` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 2 | 0 command, 1 config, 2 byte count, 3 reason clear |
| reg_wdata | input | CNT_W | Register write data |
| ext_ack | input | 1 | Slave-role acknowledge from the external side |
| ext_rd | input | 1 | Slave-role read strobe |
| ext_wr | input | 1 | Slave-role write strobe |
| eot_in | input | 1 | External end-of-transfer pulse |
| short_pkt | input | 1 | Short-packet flag from the packet engine |
| dreq | output | 1 | Data request, slave role |
| mst_ack | output | 1 | Master-role acknowledge strobe |
| mst_rd | output | 1 | Master-role read strobe |
| mst_wr | output | 1 | Master-role write strobe |
| busy | output | 1 | Transfer in progress |
| reason | output | 3 | Sticky cause bits: 0 short packet, 1 external EOT, 2 count done |
| cnt_left | output | CNT_W | Remaining byte count |

## Verification
The termination logic is driven with each cause alone, in slave and master roles, with the counter on and off, and with both bus widths, including an odd count on the wide bus and a count that is zero at start. Each pattern is identified by the reason bits it leaves behind and by the remaining count. The remaining count shows whether the counter was active and which step size it used. Master runs hold the external EOT pin high throughout and count each strobe line separately, so the selector decode and the direction decode are checked against each other. Directed cases cover simultaneous causes, commands ignored while busy, illegal opcodes, and a clear that collides with a new cause.

// File: rtl/xfer_dma_pkg.sv
package xfer_dma_pkg;
  localparam logic [7:0] OP_SLV_RD = 8'h00;
  localparam logic [7:0] OP_SLV_WR = 8'h01;
  localparam logic [7:0] OP_MST_RD = 8'h06;
  localparam logic [7:0] OP_MST_WR = 8'h07;
  localparam logic [7:0] OP_STOP   = 8'h0F;

  localparam int CAUSE_W     = 3;
  localparam int CAUSE_SHORT = 0;
  localparam int CAUSE_EXT   = 1;
  localparam int CAUSE_CNT   = 2;

  localparam logic [1:0] ADDR_CMD = 2'd0;
  localparam logic [1:0] ADDR_CFG = 2'd1;
  localparam logic [1:0] ADDR_CNT = 2'd2;
  localparam logic [1:0] ADDR_CLR = 2'd3;

  typedef enum logic [1:0] {
    STB_RW    = 2'd0,
    STB_ACK   = 2'd1,
    STB_BOTH  = 2'd2,
    STB_BOTHX = 2'd3
  } stb_sel_e;

  typedef struct packed {
    stb_sel_e stb_sel;
    logic     cnt_off;
    logic     wide;
  } dma_cfg_t;
endpackage

// File: rtl/xfer_dma_counter.sv
module xfer_dma_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             active,
  input  logic             word,
  input  logic             wide,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_zero
);
  function automatic logic [CNT_W-1:0] step_of(input logic w);
    return w ? CNT_W'(2) : CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] sat_sub(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] s);
    return (c > s) ? (c - s) : '0;
  endfunction

  logic [CNT_W-1:0] step;
  assign step     = step_of(wide);
  assign hit_zero = active && ((cnt == '0) || (word && (cnt <= step)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (active && word)  cnt <= sat_sub(cnt, step);
  end

  // R3
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/xfer_dma_strobe.sv
module xfer_dma_strobe
  import xfer_dma_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     dir_wr,
  input  stb_sel_e sel,
  output logic     word,
  output logic     mst_ack,
  output logic     mst_rd,
  output logic     mst_wr
);
  logic phase;
  logic ack_on, rw_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= 1'b0;
    else if (run) phase <= ~phase;
    else          phase <= 1'b0;
  end

  assign ack_on  = (sel != STB_RW);
  assign rw_on   = (sel != STB_ACK);
  assign word    = run && phase;
  assign mst_ack = word && ack_on;
  assign mst_rd  = word && rw_on && !dir_wr;
  assign mst_wr  = word && rw_on && dir_wr;

  // R7
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mst_rd, mst_wr}));
  // R7
  stb_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word |=> !word);
endmodule

// File: rtl/xfer_dma_reason.sv
module xfer_dma_reason #(
  parameter int CAUSE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] set_vec,
  input  logic               clr_we,
  input  logic [CAUSE_W-1:0] clr_vec,
  output logic [CAUSE_W-1:0] reason
);
  logic [CAUSE_W-1:0] clr_mask;
  assign clr_mask = clr_we ? clr_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reason <= '0;
    else        reason <= (reason & ~clr_mask) | set_vec;
  end

  // R10
  rsn_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (($past(reason) & ~reason) == '0));
endmodule

// File: rtl/xfer_dma_ctrl.sv
module xfer_dma_ctrl
  import xfer_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  input  logic               ext_ack,
  input  logic               ext_rd,
  input  logic               ext_wr,
  input  logic               eot_in,
  input  logic               short_pkt,
  output logic               dreq,
  output logic               mst_ack,
  output logic               mst_rd,
  output logic               mst_wr,
  output logic               busy,
  output logic [CAUSE_W-1:0] reason,
  output logic [CNT_W-1:0]   cnt_left
);
  localparam int CFG_W = $bits(dma_cfg_t);

  dma_cfg_t   cfg_q;
  logic       is_mst, dir_wr;
  logic [7:0] opcode;
  logic       cmd_we, op_legal, start, stop_evt;
  logic       slv_word, mst_word, word;
  logic       ext_evt, short_evt, cnt_evt, term;
  logic       cnt_on;
  logic [CAUSE_W-1:0] cause_vec;

  assign opcode   = reg_wdata[7:0];
  assign cmd_we   = reg_we && (reg_addr == ADDR_CMD);
  assign op_legal = (opcode == OP_SLV_RD) || (opcode == OP_SLV_WR) ||
                    (opcode == OP_MST_RD) || (opcode == OP_MST_WR);
  assign start    = cmd_we && !busy && op_legal;
  assign stop_evt = cmd_we && busy && (opcode == OP_STOP);

  assign slv_word  = busy && !is_mst && ext_ack && (ext_rd || ext_wr);
  assign word      = slv_word || mst_word;
  assign ext_evt   = busy && !is_mst && eot_in;
  assign short_evt = busy && short_pkt;
  assign cnt_on    = busy && (is_mst || !cfg_q.cnt_off);
  assign term      = ext_evt || short_evt || cnt_evt || stop_evt;

  always_comb begin
    cause_vec              = '0;
    cause_vec[CAUSE_SHORT] = short_evt;
    cause_vec[CAUSE_EXT]   = ext_evt;
    cause_vec[CAUSE_CNT]   = cnt_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      is_mst <= 1'b0;
      dir_wr <= 1'b0;
      cfg_q  <= '0;
    end else begin
      if (start) begin
        busy   <= 1'b1;
        is_mst <= opcode[2];
        dir_wr <= opcode[0];
      end else if (term) begin
        busy   <= 1'b0;
      end
      if (reg_we && (reg_addr == ADDR_CFG) && !busy)
        cfg_q <= dma_cfg_t'(reg_wdata[CFG_W-1:0]);
    end
  end

  assign dreq = busy && !is_mst;

  xfer_dma_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reg_we && (reg_addr == ADDR_CNT)),
    .load_val (reg_wdata),
    .active   (cnt_on),
    .word     (word),
    .wide     (cfg_q.wide),
    .cnt      (cnt_left),
    .hit_zero (cnt_evt)
  );

  xfer_dma_strobe u_stb (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy && is_mst),
    .dir_wr  (dir_wr),
    .sel     (cfg_q.stb_sel),
    .word    (mst_word),
    .mst_ack (mst_ack),
    .mst_rd  (mst_rd),
    .mst_wr  (mst_wr)
  );

  xfer_dma_reason #(.CAUSE_W(CAUSE_W)) u_rsn (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (cause_vec),
    .clr_we  (reg_we && (reg_addr == ADDR_CLR)),
    .clr_vec (reg_wdata[CAUSE_W-1:0]),
    .reason  (reason)
  );

  // R9
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (!busy && !dreq));
  // R8
  mst_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_mst && !short_pkt && !stop_evt && !cnt_evt) |=> busy);
  // R6
  rsn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((reason & ~$past(reason)) == '0));
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !term) |=> busy);
endmodule

// File: tb/xfer_dma_ctrl_bench.sv
module xfer_dma_ctrl_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic ext_ack = 1'b0, ext_rd = 1'b0, ext_wr = 1'b0;
  logic eot_in = 1'b0, short_pkt = 1'b0;
  logic dreq, mst_ack, mst_rd, mst_wr, busy;
  logic [2:0] reason;
  logic [CNT_W-1:0] cnt_left;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  xfer_dma_ctrl #(.CNT_W(CNT_W)) u_xfer_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ext_ack(ext_ack), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .eot_in(eot_in), .short_pkt(short_pkt), .dreq(dreq), .mst_ack(mst_ack),
    .mst_rd(mst_rd), .mst_wr(mst_wr), .busy(busy), .reason(reason),
    .cnt_left(cnt_left)
  );

  // ev: 0 none, 1 eot_in, 2 short_pkt, 3 stop opcode; cfg = {sel[1:0], cnt_off, wide}
  typedef struct packed {
    logic [7:0]  op;
    logic [3:0]  cfg;
    logic [15:0] cnt;
    logic [3:0]  nw;
    logic [1:0]  ev;
    logic [2:0]  rsn;
    logic [15:0] left;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 4'b0000, 16'd3,  4'd3, 2'd0, 3'b100, 16'd0},
    '{8'h01, 4'b0001, 16'd4,  4'd2, 2'd0, 3'b100, 16'd0},
    '{8'h00, 4'b0010, 16'd2,  4'd5, 2'd1, 3'b010, 16'd2},
    '{8'h01, 4'b0010, 16'd5,  4'd1, 2'd2, 3'b001, 16'd5},
    '{8'h00, 4'b0000, 16'd10, 4'd2, 2'd3, 3'b000, 16'd8},
    '{8'h00, 4'b0000, 16'd10, 4'd1, 2'd1, 3'b010, 16'd9},
    '{8'h01, 4'b0001, 16'd3,  4'd2, 2'd0, 3'b100, 16'd0},
    '{8'h06, 4'b0011, 16'd6,  4'd3, 2'd0, 3'b100, 16'd0},
    '{8'h07, 4'b0100, 16'd2,  4'd2, 2'd0, 3'b100, 16'd0},
    '{8'h00, 4'b0000, 16'd0,  4'd0, 2'd0, 3'b100, 16'd0},
    '{8'h07, 4'b1000, 16'd1,  4'd1, 2'd0, 3'b100, 16'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic slv_word();
    ext_ack = 1'b1; ext_rd = 1'b1;
    @(negedge clk);
    ext_ack = 1'b0; ext_rd = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int rd_n, wr_n, ack_n, dreq_n;
    logic mst, wdir, ack_on, rw_on;
    mst    = v.op[2];
    wdir   = v.op[0];
    ack_on = (v.cfg[3:2] != 2'd0);
    rw_on  = (v.cfg[3:2] != 2'd1);
    reg_wr(2'd1, CNT_W'(v.cfg));
    reg_wr(2'd2, v.cnt);
    reg_wr(2'd0, CNT_W'(v.op));
    chk("R1 busy after start", busy, 1);
    if (!mst) begin
      chk("R3 dreq in slave role", dreq, 1);
      for (int i = 0; i < int'(v.nw); i++) slv_word();
      case (v.ev)
        2'd1: begin eot_in = 1'b1; @(negedge clk); eot_in = 1'b0; end
        2'd2: begin short_pkt = 1'b1; @(negedge clk); short_pkt = 1'b0; end
        2'd3: reg_wr(2'd0, CNT_W'(8'h0F));
        default: ;
      endcase
    end else begin
      rd_n = 0; wr_n = 0; ack_n = 0; dreq_n = 0;
      eot_in = 1'b1;
      for (int i = 0; i < 64; i++) begin
        if (!busy) break;
        rd_n += int'(mst_rd); wr_n += int'(mst_wr);
        ack_n += int'(mst_ack); dreq_n += int'(dreq);
        @(negedge clk);
      end
      eot_in = 1'b0;
      chk("R7 dreq low in master role", dreq_n, 0);
      chk("R7 rd strobes", rd_n, (rw_on && !wdir) ? int'(v.nw) : 0);
      chk("R7 wr strobes", wr_n, (rw_on && wdir) ? int'(v.nw) : 0);
      chk("R7 ack strobes", ack_n, ack_on ? int'(v.nw) : 0);
    end
    @(negedge clk);
    chk("R9 busy low after end", busy, 0);
    chk("R9 dreq low after end", dreq, 0);
    chk("R4 R6 R8 reason", reason, v.rsn);
    chk("R3 R5 count left", cnt_left, v.left);
    reg_wr(2'd3, CNT_W'(3'b111));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy at reset", busy, 0);
    chk("R11 dreq at reset", dreq, 0);
    chk("R11 strobes at reset", {mst_ack, mst_rd, mst_wr}, 0);
    chk("R11 reason at reset", reason, 0);
    chk("R11 count at reset", cnt_left, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R1: illegal opcode leaves block idle
    reg_wr(2'd0, CNT_W'(8'h03));
    chk("R1 illegal opcode ignored", busy, 0);

    // R2: commands ignored while busy, stop ends with no reason
    reg_wr(2'd1, CNT_W'(4'b0000));
    reg_wr(2'd2, CNT_W'(10));
    reg_wr(2'd0, CNT_W'(8'h00));
    reg_wr(2'd0, CNT_W'(8'h07));
    chk("R2 master opcode ignored while busy", dreq, 1);
    slv_word();
    chk("R2 transfer still running", cnt_left, 9);
    reg_wr(2'd0, CNT_W'(8'h0F));
    chk("R2 stop ends transfer", busy, 0);
    chk("R2 stop sets no reason", reason, 0);

    // R9: simultaneous causes on final word
    reg_wr(2'd2, CNT_W'(1));
    reg_wr(2'd0, CNT_W'(8'h01));
    ext_ack = 1'b1; ext_wr = 1'b1; eot_in = 1'b1; short_pkt = 1'b1;
    chk("R9 dreq high on ending cycle", dreq, 1);
    @(negedge clk);
    ext_ack = 1'b0; ext_wr = 1'b0; eot_in = 1'b0; short_pkt = 1'b0;
    chk("R9 all causes recorded", reason, 3'b111);
    chk("R9 dreq low next cycle", dreq, 0);

    // R10: partial clear
    reg_wr(2'd3, CNT_W'(3'b010));
    chk("R10 partial clear", reason, 3'b101);
    reg_wr(2'd3, CNT_W'(3'b111));
    chk("R10 full clear", reason, 0);

    // R10: cause beats clear in the same cycle
    reg_wr(2'd2, CNT_W'(10));
    reg_wr(2'd0, CNT_W'(8'h00));
    short_pkt = 1'b1;
    reg_wr(2'd3, CNT_W'(3'b001));
    short_pkt = 1'b0;
    chk("R10 set wins over clear", reason, 3'b001);
    chk("R6 short packet ends transfer", busy, 0);

    // R6: eot while idle sets nothing
    reg_wr(2'd3, CNT_W'(3'b111));
    eot_in = 1'b1; short_pkt = 1'b1;
    @(negedge clk);
    eot_in = 1'b0; short_pkt = 1'b0;
    chk("R6 no reason while idle", reason, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule